// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a set of control registers that exist once per hardware unit but share a single bus offset each. The units are arranged as a grid of groups and instances. A steering selector register picks one group and one instance. A broadcast flag in the selector decides how a data write is applied. When the flag is set, the write goes to every unit. When it is clear, the write goes only to the steered unit. A read always returns the steered unit's copy.

A presence vector marks units that are fused off or power-gated. An access that lands on such a unit is terminated: a read returns zero and a write is dropped.

Two agents share the bus and the selector: a host (requester ID 0) and a firmware agent (requester ID 1). A hardware semaphore settles which of them may reprogram the selector. An agent claims the semaphore by reading it and seeing 1. It gives the semaphore back by writing 1 to it.

Top module: `mcr_bank`

## Requirements
- R1: After reset the selector reads 0x8000_0000 (broadcast flag set, group 0, instance 0), the semaphore is free, and bus_rvalid is low.
- R2: The selector word holds the broadcast flag in bit 31, the group in bits [9:8] and the instance in bits [1:0]. A write stores only these fields, and every other bit reads back as 0. The selector sits at address 0, the semaphore at address 1, and the replicated offsets at addresses 8 and 9. Unit number = group*4 + instance, and this is also its bit in present_mask.
- R3: A data write made while the broadcast flag is set updates that offset in every present unit. Absent units keep their old contents.
- R4: A data write made while the broadcast flag is clear updates only the steered unit. All other units are left unchanged.
- R5: A data read returns the steered unit's value, whether the broadcast flag is set or clear.
- R6: A read steered to a unit whose present_mask bit is 0 returns 0. A unicast write to such a unit is dropped, so the unit still shows its old value once it is present again.
- R7: A semaphore read returns 1 and grants ownership when the semaphore is free. A read by the current owner also returns 1.
- R8: While one requester holds the semaphore, a semaphore read by the other returns 0, and a selector write by the other is ignored.
- R9: A write with bit 0 set, made by the owner, frees the semaphore. The same write from a requester that is not the owner is ignored, and so is a write with bit 0 clear.
- R10: Read data and bus_rvalid appear on the cycle after the read is accepted. bus_rvalid stays low after a write. Unmapped addresses read as 0.
- R11: Each replicated offset has its own storage in every unit, and a write to one offset leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_req_id | input | 1 | Requester: 0 host, 1 firmware |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| present_mask | input | 16 | One bit per unit, 1 = present and powered |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |

## Verification
The hardest situation to reach is a dropped unicast write to an absent unit. It cannot be seen while the unit is absent, because every read of that unit returns zero. The stimulus first loads distinct values by broadcast. It then gates one unit, issues a unicast write and a broadcast write at it, and finally restores the unit's presence bit and reads back the values it held before. The semaphore denials are reached by having the firmware agent claim the semaphore first. While it holds it, the host tries a release, a selector write and a semaphore read, and each attempt is checked through a later read.

// File: rtl/mcr_pkg.sv
`timescale 1ns/1ps
package mcr_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SEL  = 2'd1,
    SRC_SEM  = 2'd2,
    SRC_REPL = 2'd3
  } mcr_src_e;

  localparam logic REQ_HOST = 1'b0;
  localparam logic REQ_FW   = 1'b1;
endpackage

// File: rtl/mcr_steer.sv
`timescale 1ns/1ps
module mcr_steer #(
  parameter int DATA_W  = 32,
  parameter int GRP_W   = 2,
  parameter int INST_W  = 2,
  parameter int GRP_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_mc,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic [INST_W-1:0] wr_inst,
  output logic              mc,
  output logic [GRP_W-1:0]  grp,
  output logic [INST_W-1:0] inst,
  output logic [DATA_W-1:0] sel_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mc   <= 1'b1;
      grp  <= '0;
      inst <= '0;
    end else if (wr_en) begin
      mc   <= wr_mc;
      grp  <= wr_grp;
      inst <= wr_inst;
    end
  end

  always_comb begin
    sel_word = '0;
    sel_word[DATA_W-1] = mc;
    sel_word[GRP_LSB +: GRP_W] = grp;
    sel_word[INST_W-1:0] = inst;
  end

  // R1: selector comes out of reset in broadcast mode steered to unit 0
  p_reset_sel_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mc && grp == '0 && inst == '0));

  // R2: selector holds its fields unless written
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> ($stable(mc) && $stable(grp) && $stable(inst)));
endmodule

// File: rtl/mcr_sem.sv
`timescale 1ns/1ps
module mcr_sem (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wdata0,
  input  logic req_id,
  output logic held,
  output logic owner,
  output logic may_steer,
  output logic rd_bit_q
);
  logic is_owner;
  assign is_owner  = held && (owner == req_id);
  assign may_steer = !held || is_owner;

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      owner    <= 1'b0;
      rd_bit_q <= 1'b0;
    end else begin
      if (rd_en) begin
        rd_bit_q <= may_steer;
        if (!held) begin
          held  <= 1'b1;
          owner <= req_id;
        end
      end else if (wr_en && wdata0 && is_owner) begin
        held <= 1'b0;
      end
    end
  end

  // R8: ownership never passes directly between requesters
  p_owner_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (held && $past(held)) |-> (owner == $past(owner)));

  // R9: the semaphore is freed only by a set-bit write from its owner
  p_release_owner_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(held) |-> $past(wr_en && wdata0 && req_id == owner));
endmodule

// File: rtl/mcr_inst.sv
`timescale 1ns/1ps
module mcr_inst #(
  parameter int DATA_W = 32,
  parameter int N_REG  = 2,
  parameter int OFF_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              present_i,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [N_REG];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_off] <= wdata;
    rd_q <= mem[rd_off];
  end

  // R6: no write ever reaches a unit that is absent
  p_wr_present_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> present_i);
endmodule

// File: rtl/mcr_bank.sv
`timescale 1ns/1ps
module mcr_bank
  import mcr_pkg::*;
#(
  parameter int N_GRP     = 4,
  parameter int N_INST    = 4,
  parameter int N_REG     = 2,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int SEL_ADDR  = 0,
  parameter int SEM_ADDR  = 1,
  parameter int REPL_BASE = 8,
  parameter int GRP_LSB   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_en,
  input  logic                      bus_we,
  input  logic                      bus_req_id,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic [N_GRP*N_INST-1:0]   present_mask,
  output logic                      bus_rvalid,
  output logic [DATA_W-1:0]         bus_rdata
);
  localparam int N_UNIT = N_GRP * N_INST;
  localparam int GRP_W  = $clog2(N_GRP);
  localparam int INST_W = $clog2(N_INST);
  localparam int UIDX_W = $clog2(N_UNIT);
  localparam int OFF_W  = (N_REG > 1) ? $clog2(N_REG) : 1;
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_ADDR);
  localparam logic [ADDR_W-1:0] SEM_A  = ADDR_W'(SEM_ADDR);
  localparam logic [ADDR_W-1:0] REPL_A = ADDR_W'(REPL_BASE);
  localparam logic [ADDR_W:0]   REPL_E = (ADDR_W+1)'(REPL_BASE + N_REG);

  logic              is_sel, is_sem, is_repl, rd_req, wr_req;
  logic [OFF_W-1:0]  repl_off;
  logic              mc;
  logic [GRP_W-1:0]  grp;
  logic [INST_W-1:0] inst;
  logic [DATA_W-1:0] sel_word;
  logic [UIDX_W-1:0] steer_idx;
  logic              sem_held, sem_owner, may_steer, sem_bit_q;
  logic [N_UNIT-1:0] wr_vec;
  logic [DATA_W-1:0] unit_q [N_UNIT];

  mcr_src_e          rd_src_q;
  logic [UIDX_W-1:0] rd_unit_q;
  logic              rd_present_q;
  logic [DATA_W-1:0] sel_word_q;

  assign rd_req   = bus_en && !bus_we;
  assign wr_req   = bus_en && bus_we;
  assign is_sel   = (bus_addr == SEL_A);
  assign is_sem   = (bus_addr == SEM_A);
  assign is_repl  = (bus_addr >= REPL_A) && ({1'b0, bus_addr} < REPL_E);
  assign repl_off = OFF_W'(bus_addr - REPL_A);

  mcr_steer #(
    .DATA_W(DATA_W), .GRP_W(GRP_W), .INST_W(INST_W), .GRP_LSB(GRP_LSB)
  ) u_steer (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_req && is_sel && may_steer),
    .wr_mc   (bus_wdata[DATA_W-1]),
    .wr_grp  (bus_wdata[GRP_LSB +: GRP_W]),
    .wr_inst (bus_wdata[INST_W-1:0]),
    .mc      (mc),
    .grp     (grp),
    .inst    (inst),
    .sel_word(sel_word)
  );

  mcr_sem u_sem (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_req && is_sem),
    .wr_en    (wr_req && is_sem),
    .wdata0   (bus_wdata[0]),
    .req_id   (bus_req_id),
    .held     (sem_held),
    .owner    (sem_owner),
    .may_steer(may_steer),
    .rd_bit_q (sem_bit_q)
  );

  assign steer_idx = UIDX_W'(int'(grp) * N_INST + int'(inst));

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    assign wr_vec[u] = wr_req && is_repl && present_mask[u] &&
                       (mc || (steer_idx == UIDX_W'(u)));

    mcr_inst #(
      .DATA_W(DATA_W), .N_REG(N_REG), .OFF_W(OFF_W)
    ) u_inst (
      .clk      (clk),
      .rst      (rst),
      .present_i(present_mask[u]),
      .wr_en    (wr_vec[u]),
      .wr_off   (repl_off),
      .wdata    (bus_wdata),
      .rd_off   (repl_off),
      .rd_q     (unit_q[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid   <= 1'b0;
      rd_src_q     <= SRC_NONE;
      rd_unit_q    <= '0;
      rd_present_q <= 1'b0;
      sel_word_q   <= '0;
    end else begin
      bus_rvalid   <= rd_req;
      rd_unit_q    <= steer_idx;
      rd_present_q <= present_mask[steer_idx];
      sel_word_q   <= sel_word;
      if (!rd_req)      rd_src_q <= SRC_NONE;
      else if (is_sel)  rd_src_q <= SRC_SEL;
      else if (is_sem)  rd_src_q <= SRC_SEM;
      else if (is_repl) rd_src_q <= SRC_REPL;
      else              rd_src_q <= SRC_NONE;
    end
  end

  always_comb begin
    case (rd_src_q)
      SRC_SEL:  bus_rdata = sel_word_q;
      SRC_SEM:  bus_rdata = DATA_W'(sem_bit_q);
      SRC_REPL: bus_rdata = rd_present_q ? unit_q[rd_unit_q] : '0;
      default:  bus_rdata = '0;
    endcase
  end

  // R6: a read steered to an absent unit returns zero
  p_term_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && is_repl && !present_mask[steer_idx]) |=> (bus_rdata == '0));

  // R4: in unicast mode at most one unit is written
  p_unicast_one_r4: assert property (@(posedge clk) disable iff (rst)
    !mc |-> $onehot0(wr_vec));

  // R10: a read is answered on the next cycle, nothing else raises valid
  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);
  p_no_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);

  // R8: the selector changes only for a requester allowed to steer
  p_sel_guard_r8: assert property (@(posedge clk) disable iff (rst)
    (sem_held && sem_owner != bus_req_id) |=> $stable(sel_word));
endmodule

// File: tb/sim_mcr_bank.sv
`timescale 1ns/1ps
module sim_mcr_bank;
  import mcr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_req_id = REQ_HOST;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] present_mask = 16'hFFFF;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  mcr_bank u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_req_id(bus_req_id), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .present_mask(present_mask), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  localparam logic [3:0] A_SEL = 4'd0, A_SEM = 4'd1, A_R0 = 4'd8, A_R1 = 4'd9;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic rid, input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_en = 1'b1; bus_we = 1'b1; bus_req_id = rid; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic rid, input logic [3:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #2;
    bus_en = 1'b1; bus_we = 1'b0; bus_req_id = rid; bus_addr = a; bus_wdata = '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle_mask(input logic [15:0] m);
    @(posedge clk); #2;
    bus_en = 1'b0; bus_we = 1'b0; present_mask = m;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
        @(posedge clk); #2; rst = 1'b0;

        rd(REQ_HOST, A_SEL, 32'h8000_0000, "R1 selector reset value");
        // semaphore arbitration
        rd(REQ_FW,   A_SEM, 32'd1, "R1 R7 free semaphore grants firmware");
        rd(REQ_HOST, A_SEM, 32'd0, "R8 host denied while firmware holds");
        rd(REQ_FW,   A_SEM, 32'd1, "R7 owner re-read");
        wr(REQ_HOST, A_SEM, 32'd1);
        rd(REQ_HOST, A_SEM, 32'd0, "R9 non-owner release ignored");
        wr(REQ_HOST, A_SEL, 32'h0000_0302);
        rd(REQ_HOST, A_SEL, 32'h8000_0000, "R8 non-owner selector write ignored");
        wr(REQ_FW,   A_SEM, 32'd0);
        rd(REQ_HOST, A_SEM, 32'd0, "R9 zero write does not release");
        wr(REQ_FW,   A_SEM, 32'd1);
        rd(REQ_HOST, A_SEM, 32'd1, "R9 owner release then host acquires");

        // broadcast fill
        wr(REQ_HOST, A_R0, 32'hA5A5_0001);
        wr(REQ_HOST, A_R1, 32'h1111_2222);
        idle_mask(16'hFFFF);
        @(negedge clk);
        check("R10 no rvalid after write", {31'd0, bus_rvalid}, 32'd0);

        // unicast to group 1 instance 2 (unit 6)
        wr(REQ_HOST, A_SEL, 32'h0000_0102);
        wr(REQ_HOST, A_R0,  32'hDEAD_BEEF);
        rd(REQ_HOST, A_SEL, 32'h0000_0102, "R2 selector fields read back");
        rd(REQ_HOST, A_R0,  32'hDEAD_BEEF, "R5 read in unicast mode");
        wr(REQ_HOST, A_SEL, 32'hFFFF_FFFF);
        rd(REQ_HOST, A_SEL, 32'h8000_0303, "R2 unused selector bits read zero");
        wr(REQ_HOST, A_SEL, 32'h8000_0102);
        rd(REQ_HOST, A_R0,  32'hDEAD_BEEF, "R4 R5 steered unit written");
        rd(REQ_HOST, A_R1,  32'h1111_2222, "R11 other offset unchanged");
        wr(REQ_HOST, A_SEL, 32'h8000_0000);
        rd(REQ_HOST, A_R0,  32'hA5A5_0001, "R4 unit 0 untouched by unicast");
        wr(REQ_HOST, A_SEL, 32'h8000_0303);
        rd(REQ_HOST, A_R0,  32'hA5A5_0001, "R3 broadcast reached unit 15");

        // termination
        idle_mask(16'hFFBF);
        wr(REQ_HOST, A_SEL, 32'h8000_0102);
        rd(REQ_HOST, A_R0,  32'h0000_0000, "R6 absent unit reads zero");
        wr(REQ_HOST, A_SEL, 32'h0000_0102);
        wr(REQ_HOST, A_R0,  32'h0000_1234);
        wr(REQ_HOST, A_SEL, 32'h8000_0000);
        wr(REQ_HOST, A_R1,  32'h5555_5555);
        rd(REQ_HOST, A_R0,  32'hA5A5_0001, "R6 unicast drop left unit 0 alone");
        idle_mask(16'hFFFF);
        wr(REQ_HOST, A_SEL, 32'h8000_0102);
        rd(REQ_HOST, A_R0,  32'hDEAD_BEEF, "R6 dropped unicast write");
        rd(REQ_HOST, A_R1,  32'h1111_2222, "R3 absent unit skipped by broadcast");
        wr(REQ_HOST, A_SEL, 32'h8000_0001);
        rd(REQ_HOST, A_R1,  32'h5555_5555, "R3 R11 broadcast to present unit");
        rd(REQ_HOST, 4'd5,  32'h0000_0000, "R10 unmapped address");
        idle_mask(16'hFFFF);
        repeat (3) @(negedge clk);
        check("R10 all reads answered", exp_q.size(), 32'd0);
      end
      begin
        repeat (5000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule